// File: doc/BRIEF.md
# Low-Frequency Clock Divider Control

This block holds the one-byte control register for a slow on-chip clock source and derives the divided clock from that source. The raw oscillator output arrives as the `osc_in` input. It is synchronised into the system clock domain, and each of its edges, rising or falling, becomes an event. A counter of events produces `div_out`, which has a 50 % duty cycle. The block also produces `div_stb`, a one-cycle strobe marking each rising edge of `div_out`. Software writes the register to turn the source on, choose the post-divide ratio and set a four-bit frequency trim. The trim goes straight to the analog core on `trim_out`.

The register also carries a read-only ready flag. Ready rises once a programmable number of divided-clock rising edges has been seen after enable, or after the divide ratio changes. Rewriting the ratio with a different value drops ready, and the count starts again. A new ratio is taken up only when the divided output falls, so the output never carries a shortened pulse.

Top module: `lfo_ctrl`

## Requirements
- R1: After reset, `rd_data` reads the enable bit as 0, ready as 0, the trim field as `TRIM_RST` (default 4'h8, so the byte reads 8'h20) and the divide select as 00. `div_out` and `div_stb` are low.
- R2: The register byte is laid out as follows: bit 7 is enable, bit 6 is ready (read-only), bits 5:2 are trim and bits 1:0 are the divide select. A write loads bits 7, 5:2 and 1:0 in the cycle after `wr_en`.
- R3: The divide select sets the ratio N of divided-clock period to oscillator period. Code 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1. Once a ratio is in force, consecutive `div_stb` pulses are N oscillator periods apart.
- R4: `div_out` stays high for exactly N oscillator half-periods, which is half of the divided period.
- R5: `trim_out` always equals the stored trim field, with no change to the bits (0000 is fastest, 1111 is slowest).
- R6: After enable is set from 0, ready rises in the cycle that follows the `SETTLE_EDGES`-th `div_stb`. Ready is 0 before that.
- R7: A write whose bits 1:0 differ from the stored divide select clears ready in the next cycle. The settle count then restarts from zero.
- R8: A write that keeps enable at 1 and leaves the divide select unchanged does not clear ready. The value written to bit 6 has no effect.
- R9: While enable is 0, `div_out` is low, `div_stb` does not pulse and ready reads 0.
- R10: A new divide select takes effect only when `div_out` falls. Every high pulse therefore has the full length for either the old ratio or the new one.
- R11: `div_stb` is high for exactly one cycle, and only in the cycle where `div_out` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Raw slow oscillator output, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| trim_out | output | 4 | Trim code sent to the oscillator core |
| div_out | output | 1 | Divided clock, a register in the `clk` domain |
| div_stb | output | 1 | One-cycle pulse on each rising edge of `div_out` |

## Verification
A write becomes visible on `rd_data` and `trim_out` one cycle after `wr_en`, and the bench samples it at the following falling clock edge. Ready moves one cycle after its cause. The bench therefore checks for a clear one falling edge after the changing write, and checks that ready is still low at the falling edge where the final settling strobe is seen and high at the next one. Divider timing is measured only as differences between strobe and edge times, so the fixed synchroniser delay drops out. Writes are placed just after a strobe, so no write lands in the same cycle as a counted edge, and each period measurement skips the strobes that may still run at the old ratio.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

    localparam int SEL_W   = 2;
    localparam int TRIM_W  = 4;
    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int CNT_W   = MAX_LOG;

    typedef struct packed {
        logic              en;
        logic [TRIM_W-1:0] trim;
        logic [SEL_W-1:0]  dsel;
    } lfo_cfg_t;

    // Last event index of one half-period: code 00 -> 8 events, 11 -> 1 event.
    function automatic logic [CNT_W-1:0] half_last(input logic [SEL_W-1:0] sel);
        logic [CNT_W:0] n;
        n = (CNT_W+1)'(1 << MAX_LOG) >> sel;
        return CNT_W'(n - (CNT_W+1)'(1));
    endfunction

    function automatic lfo_cfg_t unpack_cfg(input logic [7:0] b);
        lfo_cfg_t c;
        c.en   = b[7];
        c.trim = b[5:2];
        c.dsel = b[1:0];
        return c;
    endfunction

    function automatic logic [7:0] pack_view(input lfo_cfg_t c, input logic rdy);
        return {c.en, rdy, c.trim, c.dsel};
    endfunction

endpackage

// File: rtl/lfo_edge.sv
module lfo_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_in,
    output logic osc_evt
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], osc_in};
    end

    assign osc_evt = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/lfo_div.sv
module lfo_div
    import lfo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             osc_evt,
    input  logic [SEL_W-1:0] req_sel,
    output logic             div_out,
    output logic             div_stb
);
    logic [SEL_W-1:0] cur_sel;
    logic [CNT_W-1:0] cnt;
    logic             out_q, stb_q;
    logic             at_last;

    assign at_last = (cnt == half_last(cur_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sel <= '0;
            cnt     <= '0;
            out_q   <= 1'b0;
            stb_q   <= 1'b0;
        end else if (!en) begin
            cur_sel <= req_sel;
            cnt     <= '0;
            out_q   <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (osc_evt) begin
                if (at_last) begin
                    cnt   <= '0;
                    out_q <= !out_q;
                    stb_q <= !out_q;
                    if (out_q) cur_sel <= req_sel;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign div_out = out_q;
    assign div_stb = stb_q;

    // R10: the ratio in force only moves while the output is low
    a_r10_sel_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (cur_sel != $past(cur_sel)) |-> !out_q);
    // R4: output only toggles after an oscillator event or a disable
    a_r4_toggle_on_event: assert property (@(posedge clk) disable iff (rst)
        (out_q && !$past(out_q)) |-> $past(osc_evt));
endmodule

// File: rtl/lfo_reg.sv
module lfo_reg
    import lfo_pkg::*;
#(
    parameter int              SETTLE_EDGES = 4,
    parameter logic [TRIM_W-1:0] TRIM_RST   = 4'h8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [7:0] wr_data,
    input  logic     div_stb,
    output lfo_cfg_t cfg,
    output logic     ready
);
    localparam int SCNT_W = $clog2(SETTLE_EDGES) + 1;
    localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SETTLE_EDGES - 1);

    lfo_cfg_t          wr_cfg;
    logic              next_en, sel_change, restart;
    logic [SCNT_W-1:0] scnt;

    assign wr_cfg     = unpack_cfg(wr_data);
    assign sel_change = wr_en && (wr_cfg.dsel != cfg.dsel);
    assign next_en    = wr_en ? wr_cfg.en : cfg.en;
    assign restart    = !next_en || sel_change;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en   <= 1'b0;
            cfg.trim <= TRIM_RST;
            cfg.dsel <= '0;
            ready    <= 1'b0;
            scnt     <= '0;
        end else begin
            if (wr_en) cfg <= wr_cfg;
            if (restart) begin
                ready <= 1'b0;
                scnt  <= '0;
            end else if (!ready && div_stb) begin
                if (scnt == SCNT_LAST) ready <= 1'b1;
                else                   scnt  <= scnt + SCNT_W'(1);
            end
        end
    end

    // R7: changing the divide select drops ready
    a_r7_sel_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[1:0] != cfg.dsel) |=> !ready);
    // R8: rewriting the same select with enable kept keeps ready
    a_r8_same_sel_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7] && wr_data[1:0] == cfg.dsel && ready) |=> ready);
    // R6: ready only rises after a divided edge
    a_r6_ready_after_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(div_stb));
    // R9: no ready while disabled
    a_r9_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !ready);
endmodule

// File: rtl/lfo_ctrl.sv
module lfo_ctrl
    import lfo_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int          SETTLE_EDGES = 4,
    parameter logic [3:0]  TRIM_RST     = 4'h8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_in,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [3:0] trim_out,
    output logic       div_out,
    output logic       div_stb
);
    lfo_cfg_t cfg;
    logic     ready;
    logic     osc_evt;

    lfo_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst(rst), .osc_in(osc_in), .osc_evt(osc_evt)
    );

    lfo_div div_i (
        .clk(clk), .rst(rst), .en(cfg.en), .osc_evt(osc_evt),
        .req_sel(cfg.dsel), .div_out(div_out), .div_stb(div_stb)
    );

    lfo_reg #(.SETTLE_EDGES(SETTLE_EDGES), .TRIM_RST(TRIM_RST)) reg_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .div_stb(div_stb), .cfg(cfg), .ready(ready)
    );

    assign rd_data  = pack_view(cfg, ready);
    assign trim_out = cfg.trim;

    // R9: output forced low one cycle after enable reads 0
    a_r9_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !rd_data[7] |=> !div_out);
    // R11: strobe marks the rising edge of the divided output only
    a_r11_stb_on_rise: assert property (@(posedge clk) disable iff (rst)
        div_stb |-> (div_out && !$past(div_out)));
    a_r11_stb_single: assert property (@(posedge clk) disable iff (rst)
        div_stb |=> !div_stb);
endmodule

// File: tb/lfo_ctrl_tb_top.sv
`timescale 1ns/1ps
module lfo_ctrl_tb_top;
    localparam int SETTLE   = 4;
    localparam int OSC_HALF = 4;          // clk cycles per oscillator half-period
    localparam int LIMIT    = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] trim_out;
    logic       div_out, div_stb;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    lfo_ctrl #(.SETTLE_EDGES(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .osc_in(osc_in), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .trim_out(trim_out), .div_out(div_out), .div_stb(div_stb)
    );

    always #10 clk = ~clk;
    always #(20 * OSC_HALF) osc_in = ~osc_in;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ratio(input logic [1:0] sel);
        return 8 >> sel;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= LIMIT);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
        finish_run();
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_stb();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!div_stb && guard < 2000);
    endtask

    task automatic measure(output int period, output int high);
        int t0;
        int h;
        wait_stb();
        t0 = cyc;
        h = 1;
        @(negedge clk);
        while (div_out) begin
            h++;
            @(negedge clk);
        end
        high = h;
        while (!div_stb) @(negedge clk);
        period = cyc - t0;
    endtask

    initial begin
        int per, hi, cnt;
        logic [1:0] sel;
        logic [3:0] trim;
        void'($urandom(32'h51C0));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rd_data == 8'h20, "R1 reset byte", rd_data, 8'h20);
        check(!div_out && !div_stb, "R1 outputs low", div_out, 0);
        check(trim_out == 4'h8, "R5 reset trim", trim_out, 8);

        // R9 disabled: bit 6 written is ignored, no activity
        do_write(8'h43);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_out || div_stb || rd_data[6]) cnt++;
        end
        check(cnt == 0, "R9 idle while disabled", cnt, 0);
        check(rd_data == 8'h03, "R8 bit6 ignored when off", rd_data, 8'h03);

        // R6 settle after enable with divide-by-1
        do_write(8'h83);
        for (int k = 0; k < SETTLE; k++) wait_stb();
        check(rd_data[6] == 1'b0, "R6 not ready at last edge", rd_data[6], 0);
        @(negedge clk);
        check(rd_data[6] == 1'b1, "R6 ready after settle", rd_data[6], 1);

        // R8 same select rewrite keeps ready, bit 6 value irrelevant
        wait_stb();
        do_write(8'hBF);
        check(rd_data == 8'hFF, "R8 same sel keeps ready", rd_data, 8'hFF);
        check(trim_out == 4'hF, "R5 trim slowest", trim_out, 15);
        wait_stb();
        do_write(8'h83);
        repeat (20) @(negedge clk);
        check(rd_data == 8'hC3, "R8 ready still set", rd_data, 8'hC3);

        // R7 changing select clears then resettles
        wait_stb();
        do_write(8'h82);
        check(rd_data[6] == 1'b0, "R7 cleared on change", rd_data[6], 0);
        for (int k = 0; k < SETTLE; k++) wait_stb();
        check(rd_data[6] == 1'b0, "R7 not ready at last edge", rd_data[6], 0);
        @(negedge clk);
        check(rd_data[6] == 1'b1, "R7 ready after resettle", rd_data[6], 1);

        // R10 change from /8 to /1 while output high
        do_write(8'h80);
        repeat (3) wait_stb();
        begin
            int t0, tf;
            wait_stb();
            t0 = cyc;
            do_write(8'h83);
            while (div_out) @(negedge clk);
            tf = cyc;
            check(tf - t0 == 8 * OSC_HALF, "R10 old high kept", tf - t0, 8 * OSC_HALF);
            while (!div_stb) @(negedge clk);
            check(cyc - t0 == 9 * OSC_HALF, "R10 switch at fall", cyc - t0, 9 * OSC_HALF);
        end
        measure(per, hi);
        check(hi == OSC_HALF, "R4 high after switch", hi, OSC_HALF);

        // R3/R4/R2/R5 random configurations
        for (int it = 0; it < 14; it++) begin
            sel  = 2'($urandom_range(0, 3));
            trim = 4'($urandom_range(0, 15));
            if (it < 4) sel = 2'(it);
            do_write({1'b1, 1'b0, trim, sel});
            check(rd_data[7] == 1'b1 && rd_data[5:0] == {trim, sel}, "R2 layout",
                  rd_data[5:0], {trim, sel});
            check(trim_out == trim, "R5 trim passthrough", trim_out, trim);
            wait_stb();
            measure(per, hi);
            check(per == 2 * OSC_HALF * ratio(sel), "R3 period", per, 2 * OSC_HALF * ratio(sel));
            check(hi == OSC_HALF * ratio(sel), "R4 duty", hi, OSC_HALF * ratio(sel));
        end

        // R11 strobe width
        wait_stb();
        @(negedge clk);
        check(!div_stb && div_out, "R11 one-cycle strobe", div_stb, 0);

        // R9 disable from running
        do_write(8'h01);
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_out || div_stb || rd_data[6]) cnt++;
        end
        check(cnt == 0, "R9 quiet after disable", cnt, 0);

        finish_run();
    end
endmodule